// File: doc/BRIEF.md
# Excess-3 Digit Adder/Subtractor with Packed BCD Result

This combinational unit takes two decimal digits, each presented as a 4-bit excess-3 code word (digit value plus three), together with a mode select. In add mode it forms the decimal sum. In subtract mode it forms the first operand minus the second. Either way, the result appears as a packed two-digit BCD word, with the tens digit in the upper nibble and the units digit in the lower nibble. The word can go straight to a BCD-to-segment converter.

For subtraction, the unit reports the magnitude of the difference in the BCD word and raises a separate sign flag when the result is negative. Operand codes outside the excess-3 digit range raise an error flag and force every result output to zero. The block holds no state and has no clock. Every output follows its inputs after gate delay only.

Top module: `xs3_addsub_bcd`

## Requirements
- R1: An operand code is legal only when it lies in 0011..1100 (digit 0..9). If either operand code is outside that range, `bad` is 1; otherwise `bad` is 0.
- R2: While `bad` is 1, `bcd_out` is 8'h00 and `neg` is 0.
- R3: With `sub`=0 and legal operands, `bcd_out` holds the decimal value A+B, with the tens digit in bits [7:4] and the units digit in bits [3:0].
- R4: With `sub`=0, `neg` is always 0.
- R5: With `sub`=1, legal operands and A>=B, `neg` is 0 and `bcd_out` holds A-B.
- R6: With `sub`=1, legal operands and B>A, `neg` is 1 and `bcd_out` holds B-A.
- R7: Every result is valid packed BCD. The units nibble is 0..9 and the tens nibble is 0 or 1; in subtract mode the tens nibble is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_xs3 | input | 4 | First operand, excess-3 coded |
| b_xs3 | input | 4 | Second operand, excess-3 coded |
| sub | input | 1 | 0 selects add, 1 selects subtract (A minus B) |
| bcd_out | output | 8 | Packed BCD result: tens in [7:4], units in [3:0] |
| neg | output | 1 | 1 when the subtract result is negative |
| bad | output | 1 | 1 when either operand is not a legal excess-3 digit |

## Verification
The block has no parameters, so the bench builds it exactly as it is: two 4-bit operand codes and one mode bit. That small input space lets the bench apply all 512 input combinations. This covers the 100 legal digit pairs in both modes, plus every illegal code on each operand. Expected values come from plain decimal arithmetic on the decoded digits. The sweep therefore reaches the decimal carry boundary at a sum of 10, the largest sum of 18, equal operands giving a zero difference, and every negative difference.

// File: rtl/xs3_addsub_bcd.sv
module xs3_addsub_bcd (
  input  logic [3:0] a_xs3,
  input  logic [3:0] b_xs3,
  input  logic       sub,
  output logic [7:0] bcd_out,
  output logic       neg,
  output logic       bad
);

  logic       a_ok, b_ok;
  logic [4:0] sum_raw, dif_raw;
  logic       dec_carry, borrow;
  logic [3:0] add_units, sub_mag;
  logic [7:0] result;

  assign a_ok = (a_xs3 >= 4'd3) && (a_xs3 <= 4'd12);
  assign b_ok = (b_xs3 >= 4'd3) && (b_xs3 <= 4'd12);
  assign bad  = !(a_ok && b_ok);

  // Excess-3 sum carries an offset of 6; a carry out of bit 3 means A+B >= 10.
  assign sum_raw   = {1'b0, a_xs3} + {1'b0, b_xs3};
  assign dec_carry = sum_raw[4];
  assign add_units = dec_carry ? sum_raw[3:0] : sum_raw[3:0] - 4'd6;

  // Offsets cancel in the difference; a borrow marks a negative result.
  assign dif_raw = {1'b0, a_xs3} - {1'b0, b_xs3};
  assign borrow  = dif_raw[4];
  assign sub_mag = borrow ? (4'd0 - dif_raw[3:0]) : dif_raw[3:0];

  assign result  = sub ? {4'd0, sub_mag} : {3'd0, dec_carry, add_units};
  assign bcd_out = bad ? 8'h00 : result;
  assign neg     = !bad && sub && borrow;

endmodule

module xs3_addsub_bcd_chk (
  input logic [3:0] a_xs3,
  input logic [3:0] b_xs3,
  input logic       sub,
  input logic [7:0] bcd_out,
  input logic       neg,
  input logic       bad
);

  always_comb begin
    assert_low_code_bad_R1: assert (!((a_xs3 < 4'd3) || (b_xs3 > 4'd12)) || bad)
      else $error("illegal operand code not flagged");
    assert_bad_zero_R2: assert (!bad || (bcd_out == 8'h00 && !neg))
      else $error("result not cleared while operand is illegal");
    assert_add_positive_R4: assert (sub || !neg)
      else $error("sign raised in add mode");
    assert_bcd_legal_R7: assert (bcd_out[3:0] <= 4'd9 && bcd_out[7:4] <= 4'd1)
      else $error("result is not packed BCD");
    assert_sub_one_digit_R5: assert (!sub || bcd_out[7:4] == 4'd0)
      else $error("difference has nonzero tens digit");
    assert_neg_nonzero_R6: assert (!neg || bcd_out[3:0] != 4'd0)
      else $error("negative result with zero magnitude");
  end

endmodule

bind xs3_addsub_bcd xs3_addsub_bcd_chk u_chk (.*);

// File: tb/xs3_addsub_bcd_bench.sv
module xs3_addsub_bcd_bench;

  logic       clk = 1'b0;
  logic [3:0] a_xs3 = 4'd0, b_xs3 = 4'd0;
  logic       sub = 1'b0;
  logic [7:0] bcd_out;
  logic       neg, bad;
  int         n_checks = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  xs3_addsub_bcd u_xs3_addsub_bcd (
    .a_xs3(a_xs3), .b_xs3(b_xs3), .sub(sub),
    .bcd_out(bcd_out), .neg(neg), .bad(bad)
  );

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s a=%h b=%h sub=%b actual={neg,bad,bcd}=%h expected=%h",
               req, a_xs3, b_xs3, sub, act, exp);
    end
  endtask

  initial begin
    @(negedge clk);
    check("R1", {neg, bad, bcd_out}, {1'b0, 1'b1, 8'h00});
    for (int m = 0; m < 2; m++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          int da, db, v;
          logic xneg, xbad;
          logic [7:0] xbcd;
          string req;
          @(posedge clk);
          a_xs3 = 4'(a); b_xs3 = 4'(b); sub = m[0];
          da = a - 3; db = b - 3;
          xbad = !(da >= 0 && da <= 9 && db >= 0 && db <= 9);
          xneg = 1'b0; xbcd = 8'h00;
          if (xbad) req = (m == 0) ? "R1 R2 add" : "R1 R2 sub";
          else if (m == 0) begin
            v = da + db; req = "R3 R4 R7";
            xbcd = {4'(v / 10), 4'(v % 10)};
          end else if (da >= db) begin
            v = da - db; req = "R5 R7";
            xbcd = {4'd0, 4'(v)};
          end else begin
            v = db - da; req = "R6 R7"; xneg = 1'b1;
            xbcd = {4'd0, 4'(v)};
          end
          @(negedge clk);
          check(req, {neg, bad, bcd_out}, {xneg, xbad, xbcd});
        end
      end
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule